// File: doc/BRIEF.md
# Control-Flow Enforcement State Checker

This block sits beside a processor pipeline and watches one control-flow event per cycle, tapped from an early stage: the current PC, the instruction word and the PC the core will fetch next. It classifies each instruction as a conditional branch, a plain jump, a call or a return. It then checks that instruction against the active per-function enforcement machine. The state of that machine is kept as a pair (machine ID, state ID). The legal targets of every state live in an external transition table. The targets are narrow IDs, which the block resolves into full addresses through a per-machine local offset table and one global entry table.

A legal event moves the checker into its next machine and state. In the same cycle the block requests the transition entry of that new state, so the entry is loaded before the next event. A call pushes a return point to an external shadow stack, and a return pops one. An illegal event drives the core reset request at once, and that request stays high.

The event input follows a valid/stall rule that acts as back-pressure. An event is accepted in a cycle where `ev_valid` is high and `stall_req` is low. While `stall_req` is high, the core must hold the same event on the inputs. `stall_req` is only ever high when a control-flow event is presented. It never lasts longer than one cycle.

Top module: `cfe_checker`

## Requirements
- R1: While `rst_n` is low, and afterwards until `cfg_done` is sampled high, `core_rst_req` is 1 and `stall_req`, `ss_push` and `ss_pop` are 0. In the cycle `cfg_done` is first high, the block requests the entry of machine 0, state 0 (`tt_addr` = 0). From the next cycle `core_rst_req` is 0.
- R2: Decoding uses instruction bits [6:0] as opcode, [11:7] as destination register and [19:15] as source register. The classes are:
  - Opcode 1100011 is a conditional branch.
  - Opcode 1101111 or 1100111 with destination 1 is a call.
  - Opcode 1100111 with destination 0 and source 1 is a return.
  - Any other 1101111/1100111 form is a jump.
  - Everything else is not control flow.
- R3: A transition entry is {fallthrough bit, slot1, slot0}. Each slot is {call flag, ID, next machine, next state} from MSB to LSB. A branch or jump is legal if a non-call slot gives base + local[{current machine, ID}] equal to the next PC. Here base is global[current machine]. The new state is (current machine, slot next state), and slot 0 wins if both slots match.
- R4: A conditional branch is legal with new state (current machine, current state + 1) when the fallthrough bit is set and the next PC equals PC + 4. This rule is checked before the slots.
- R5: A call is legal if a call slot gives global[ID] equal to the next PC. The new state is (slot next machine, 0). In the same cycle `ss_push` is 1 with `ss_push_mach` = current machine and `ss_push_state` = the slot's next-state field.
- R6: A return is legal only when the current entry has a slot whose bits are all ones and `ss_empty` is 0. The new state is (`ss_top_mach`, `ss_top_state`), and `ss_pop` is 1 in that cycle.
- R7: An accepted control-flow event that matches no rule sets `core_rst_req` to 1 in the same cycle. It stays 1 until `rst_n` goes low.
- R8: In the cycle a legal event is accepted, `tt_en` is 1 and `tt_addr` = {new machine, new state}. The read data is expected on `tt_rdata` one cycle later.
- R9: A control-flow event in the cycle right after a legal event gets `stall_req` = 1 for exactly one cycle, with no table fetch, push or pop. The held event is judged in the following cycle.
- R10: Events that are not control flow cause no fetch, no push, no pop, no stall and no reset, and they leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_done | input | 1 | Tables are loaded; start checking |
| ev_valid | input | 1 | Pipeline event present |
| ev_pc | input | 32 | PC of the event instruction |
| ev_instr | input | 32 | Instruction word |
| ev_npc | input | 32 | Next PC the core will use |
| stall_req | output | 1 | Hold the core one cycle |
| core_rst_req | output | 1 | Keep or put the core in reset |
| tt_en | output | 1 | Transition table read enable |
| tt_addr | output | 6 | Transition table index {machine, state} |
| tt_rdata | input | 23 | Transition entry, one cycle after `tt_en` |
| lam_addr | output | 12 | Two local-table indices {machine, ID}, slot 0 in the low half |
| lam_data | input | 64 | Two local offsets, combinational |
| gam_addr | output | 12 | Global-table indices: slot 0, slot 1, current machine (high) |
| gam_data | input | 96 | Three global addresses, combinational |
| ss_push | output | 1 | Shadow stack push |
| ss_push_mach | output | 2 | Machine to return to |
| ss_push_state | output | 4 | State to return to |
| ss_pop | output | 1 | Shadow stack pop |
| ss_empty | input | 1 | Shadow stack holds nothing |
| ss_top_mach | input | 2 | Machine on top of the stack |
| ss_top_state | input | 4 | State on top of the stack |

## Verification
A wrong active state shows up at the ports in the same cycle as the next control-flow event. It appears either as a `tt_addr` that differs from the expected {machine, state} or as a false `core_rst_req`, because every later match is resolved against the entry of that state. A wrong shadow-stack record stays hidden until the matching return, where `tt_addr` reveals the restored pair. The stall handshake is visible one cycle after each fetch, so a lost or doubled pending flag shows within a cycle.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int INSTR_W = 32;

  typedef enum logic [2:0] {
    CF_NONE,
    CF_BRANCH,
    CF_JUMP,
    CF_CALL,
    CF_RET
  } cf_kind_e;

  typedef enum logic [1:0] {
    MODE_HOLD,
    MODE_RUN,
    MODE_FAULT
  } mode_e;
endpackage

// File: rtl/cfe_decode.sv
module cfe_decode
  import cfe_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output cf_kind_e           kind
);
  logic [6:0] opc;
  logic [4:0] rd;
  logic [4:0] rs1;

  assign opc = instr[6:0];
  assign rd  = instr[11:7];
  assign rs1 = instr[19:15];

  always_comb begin
    kind = CF_NONE;
    if (opc == 7'b1100011) begin
      kind = CF_BRANCH;
    end else if (opc == 7'b1101111 || opc == 7'b1100111) begin
      if (rd == 5'd1)
        kind = CF_CALL;
      else if (opc == 7'b1100111 && rd == 5'd0 && rs1 == 5'd1)
        kind = CF_RET;
      else
        kind = CF_JUMP;
    end
  end
endmodule

// File: rtl/cfe_slot_match.sv
module cfe_slot_match #(
  parameter int PC_W    = 32,
  parameter int MACH_W  = 2,
  parameter int STATE_W = 4,
  parameter int ID_W    = 4
) (
  input  logic [1+ID_W+MACH_W+STATE_W-1:0] slot,
  input  logic [MACH_W-1:0]                cur_mach,
  input  logic [PC_W-1:0]                  base,
  input  logic [PC_W-1:0]                  npc,
  input  logic [PC_W-1:0]                  lam_rd,
  input  logic [PC_W-1:0]                  gam_rd,
  output logic [MACH_W+ID_W-1:0]           lam_idx,
  output logic [ID_W-1:0]                  gam_idx,
  output logic                             marker,
  output logic                             hit_loc,
  output logic                             hit_call
);
  localparam int SLOT_W = 1 + ID_W + MACH_W + STATE_W;

  logic            is_call;
  logic [ID_W-1:0] aid;
  logic [PC_W-1:0] loc_addr;

  assign is_call  = slot[SLOT_W-1];
  assign aid      = slot[SLOT_W-2 -: ID_W];
  assign marker   = &slot;
  assign lam_idx  = {cur_mach, aid};
  assign gam_idx  = aid;
  assign loc_addr = base + lam_rd;
  assign hit_loc  = !marker && !is_call && (npc == loc_addr);
  assign hit_call = !marker &&  is_call && (npc == gam_rd);
endmodule

// File: rtl/cfe_seq.sv
module cfe_seq
  import cfe_pkg::*;
#(
  parameter int MACH_W     = 2,
  parameter int STATE_W    = 4,
  parameter int ENT_W      = 23,
  parameter int ENTRY_MACH = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_done,
  input  logic                      fire,
  input  logic                      viol,
  input  logic [MACH_W-1:0]         nxt_mach,
  input  logic [STATE_W-1:0]        nxt_state,
  input  logic [ENT_W-1:0]          tt_rdata,
  output logic                      tt_en,
  output logic [MACH_W+STATE_W-1:0] tt_addr,
  output mode_e                     mode,
  output logic [MACH_W-1:0]         cur_mach,
  output logic [STATE_W-1:0]        cur_state,
  output logic [ENT_W-1:0]          cur_ent,
  output logic                      ent_pending
);
  logic start;

  assign start   = (mode == MODE_HOLD) && cfg_done;
  assign tt_en   = start || fire;
  assign tt_addr = start ? {MACH_W'(ENTRY_MACH), STATE_W'(0)} : {nxt_mach, nxt_state};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= MODE_HOLD;
      cur_mach    <= '0;
      cur_state   <= '0;
      cur_ent     <= '0;
      ent_pending <= 1'b0;
    end else begin
      if (ent_pending) cur_ent <= tt_rdata;
      case (mode)
        MODE_HOLD: begin
          if (cfg_done) begin
            mode        <= MODE_RUN;
            cur_mach    <= MACH_W'(ENTRY_MACH);
            cur_state   <= '0;
            ent_pending <= 1'b1;
          end
        end
        MODE_RUN: begin
          ent_pending <= fire;
          if (viol) mode <= MODE_FAULT;
          if (fire) begin
            cur_mach  <= nxt_mach;
            cur_state <= nxt_state;
          end
        end
        default: begin
          mode        <= MODE_FAULT;
          ent_pending <= 1'b0;
        end
      endcase
    end
  end

  assert_fault_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAULT) |=> (mode == MODE_FAULT));
  assert_fetch_arms_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tt_en |=> ent_pending);
endmodule

// File: rtl/cfe_checker.sv
module cfe_checker
  import cfe_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int MACH_W     = 2,
  parameter int STATE_W    = 4,
  parameter int ID_W       = 4,
  parameter int ENTRY_MACH = 0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_done,
  input  logic                              ev_valid,
  input  logic [PC_W-1:0]                   ev_pc,
  input  logic [INSTR_W-1:0]                ev_instr,
  input  logic [PC_W-1:0]                   ev_npc,
  output logic                              stall_req,
  output logic                              core_rst_req,
  output logic                              tt_en,
  output logic [MACH_W+STATE_W-1:0]         tt_addr,
  input  logic [2*(1+ID_W+MACH_W+STATE_W):0] tt_rdata,
  output logic [2*(MACH_W+ID_W)-1:0]        lam_addr,
  input  logic [2*PC_W-1:0]                 lam_data,
  output logic [3*ID_W-1:0]                 gam_addr,
  input  logic [3*PC_W-1:0]                 gam_data,
  output logic                              ss_push,
  output logic [MACH_W-1:0]                 ss_push_mach,
  output logic [STATE_W-1:0]                ss_push_state,
  output logic                              ss_pop,
  input  logic                              ss_empty,
  input  logic [MACH_W-1:0]                 ss_top_mach,
  input  logic [STATE_W-1:0]                ss_top_state
);
  localparam int SLOT_W = 1 + ID_W + MACH_W + STATE_W;
  localparam int ENT_W  = 2 * SLOT_W + 1;
  localparam int LAM_AW = MACH_W + ID_W;
  localparam int NSLOT  = 2;

  cf_kind_e             kind;
  mode_e                mode;
  logic [MACH_W-1:0]    cur_mach;
  logic [STATE_W-1:0]   cur_state;
  logic [ENT_W-1:0]     cur_ent;
  logic                 ent_pending;
  logic [NSLOT-1:0]     marker, hit_loc, hit_call;
  logic [MACH_W-1:0]    s_mach  [NSLOT];
  logic [STATE_W-1:0]   s_state [NSLOT];
  logic [PC_W-1:0]      base;
  logic                 active, take, ok, fire, viol, accepting;
  logic                 push_c, pop_c;
  logic [MACH_W-1:0]    nxt_mach;
  logic [STATE_W-1:0]   nxt_state;
  logic [STATE_W-1:0]   ret_state;

  cfe_decode u_dec (.instr(ev_instr), .kind(kind));

  assign base = gam_data[2*PC_W +: PC_W];
  assign gam_addr[2*ID_W +: ID_W] = ID_W'(cur_mach);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    cfe_slot_match #(.PC_W(PC_W), .MACH_W(MACH_W), .STATE_W(STATE_W), .ID_W(ID_W)) u_sm (
      .slot     (cur_ent[i*SLOT_W +: SLOT_W]),
      .cur_mach (cur_mach),
      .base     (base),
      .npc      (ev_npc),
      .lam_rd   (lam_data[i*PC_W +: PC_W]),
      .gam_rd   (gam_data[i*PC_W +: PC_W]),
      .lam_idx  (lam_addr[i*LAM_AW +: LAM_AW]),
      .gam_idx  (gam_addr[i*ID_W +: ID_W]),
      .marker   (marker[i]),
      .hit_loc  (hit_loc[i]),
      .hit_call (hit_call[i])
    );
    assign s_state[i] = cur_ent[i*SLOT_W +: STATE_W];
    assign s_mach[i]  = cur_ent[i*SLOT_W + STATE_W +: MACH_W];
  end

  assign accepting = |marker;
  assign active    = (mode == MODE_RUN) && ev_valid && (kind != CF_NONE);
  assign stall_req = active && ent_pending;
  assign take      = active && !ent_pending;

  always_comb begin
    ok        = 1'b0;
    push_c    = 1'b0;
    pop_c     = 1'b0;
    nxt_mach  = cur_mach;
    nxt_state = cur_state;
    ret_state = '0;
    case (kind)
      CF_BRANCH, CF_JUMP: begin
        if (kind == CF_BRANCH && cur_ent[ENT_W-1] && ev_npc == ev_pc + PC_W'(4)) begin
          ok        = 1'b1;
          nxt_state = cur_state + STATE_W'(1);
        end else if (hit_loc[0]) begin
          ok        = 1'b1;
          nxt_state = s_state[0];
        end else if (hit_loc[1]) begin
          ok        = 1'b1;
          nxt_state = s_state[1];
        end
      end
      CF_CALL: begin
        if (hit_call[0] || hit_call[1]) begin
          ok        = 1'b1;
          push_c    = 1'b1;
          nxt_mach  = hit_call[0] ? s_mach[0]  : s_mach[1];
          ret_state = hit_call[0] ? s_state[0] : s_state[1];
          nxt_state = '0;
        end
      end
      CF_RET: begin
        if (accepting && !ss_empty) begin
          ok        = 1'b1;
          pop_c     = 1'b1;
          nxt_mach  = ss_top_mach;
          nxt_state = ss_top_state;
        end
      end
      default: ;
    endcase
  end

  assign fire          = take && ok;
  assign viol          = take && !ok;
  assign ss_push       = fire && push_c;
  assign ss_pop        = fire && pop_c;
  assign ss_push_mach  = cur_mach;
  assign ss_push_state = ret_state;
  assign core_rst_req  = (mode != MODE_RUN) || viol;

  cfe_seq #(.MACH_W(MACH_W), .STATE_W(STATE_W), .ENT_W(ENT_W), .ENTRY_MACH(ENTRY_MACH)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_done    (cfg_done),
    .fire        (fire),
    .viol        (viol),
    .nxt_mach    (nxt_mach),
    .nxt_state   (nxt_state),
    .tt_rdata    (tt_rdata),
    .tt_en       (tt_en),
    .tt_addr     (tt_addr),
    .mode        (mode),
    .cur_mach    (cur_mach),
    .cur_state   (cur_state),
    .cur_ent     (cur_ent),
    .ent_pending (ent_pending)
  );

  assert_stall_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> !stall_req);
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_pop |-> !ss_empty);
  assert_call_enters_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ss_push |-> (tt_en && tt_addr[STATE_W-1:0] == '0));
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_req |-> (!ss_push && !ss_pop && !stall_req));
  assert_violation_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_req && mode == MODE_RUN) |=> (core_rst_req && !tt_en));
endmodule

// File: tb/sim_cfe_checker.sv
module sim_cfe_checker;
  localparam int PC_W = 32, MACH_W = 2, STATE_W = 4, ID_W = 4;
  localparam int SLOT_W = 1 + ID_W + MACH_W + STATE_W;
  localparam int ENT_W  = 2 * SLOT_W + 1;
  localparam int LAM_AW = MACH_W + ID_W;
  localparam logic [SLOT_W-1:0] MK = '1;
  localparam logic [31:0] I_BEQ = 32'h00000063, I_CALL = 32'h000000EF, I_JMP = 32'h0000006F,
                          I_RET = 32'h00008067, I_NOP = 32'h00000013, I_ICALL = 32'h000000E7;

  logic clk = 0, rst_n = 0, cfg_done = 0, ev_valid = 0;
  logic [31:0] ev_pc = 0, ev_instr = 0, ev_npc = 0;
  logic stall_req, core_rst_req, tt_en, ss_push, ss_pop, ss_empty;
  logic [MACH_W+STATE_W-1:0] tt_addr;
  logic [ENT_W-1:0] tt_rdata;
  logic [2*LAM_AW-1:0] lam_addr;
  logic [2*PC_W-1:0] lam_data;
  logic [3*ID_W-1:0] gam_addr;
  logic [3*PC_W-1:0] gam_data;
  logic [MACH_W-1:0] ss_push_mach, ss_top_mach;
  logic [STATE_W-1:0] ss_push_state, ss_top_state;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [SLOT_W-1:0] sl(input logic c, input int aid, input int nm, input int ns);
    return {c, ID_W'(aid), MACH_W'(nm), STATE_W'(ns)};
  endfunction

  function automatic logic [ENT_W-1:0] tt_f(input logic [MACH_W+STATE_W-1:0] a);
    case (a)
      6'd0:  return {1'b1, sl(1, 1, 1, 3), sl(0, 1, 0, 2)};
      6'd1:  return {1'b0, MK, sl(0, 2, 0, 3)};
      6'd2:  return {1'b0, MK, sl(1, 1, 1, 3)};
      6'd3:  return {1'b0, MK, MK};
      6'd16: return {1'b0, sl(0, 1, 1, 1), {SLOT_W{1'b0}}};
      6'd17: return {1'b0, MK, MK};
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] lam_f(input logic [LAM_AW-1:0] a);
    case (a)
      6'h01: return 32'h20;
      6'h02: return 32'h40;
      6'h11: return 32'h10;
      default: return 32'hFFF00000;
    endcase
  endfunction

  function automatic logic [31:0] gam_f(input logic [ID_W-1:0] a);
    case (a)
      4'd0: return 32'h100;
      4'd1: return 32'h200;
      default: return 32'hFFFF0000;
    endcase
  endfunction

  assign lam_data = {lam_f(lam_addr[LAM_AW +: LAM_AW]), lam_f(lam_addr[0 +: LAM_AW])};
  assign gam_data = {gam_f(gam_addr[2*ID_W +: ID_W]), gam_f(gam_addr[ID_W +: ID_W]),
                     gam_f(gam_addr[0 +: ID_W])};

  always_ff @(posedge clk) if (tt_en) tt_rdata <= tt_f(tt_addr);

  // shadow stack model
  logic [MACH_W+STATE_W-1:0] stk [4];
  int sp = 0;
  assign ss_empty = (sp == 0);
  assign {ss_top_mach, ss_top_state} = (sp == 0) ? '0 : stk[sp-1];
  always @(posedge clk) begin
    if (!rst_n) sp <= 0;
    else if (ss_push && sp < 4) begin stk[sp] <= {ss_push_mach, ss_push_state}; sp <= sp + 1; end
    else if (ss_pop && sp > 0) sp <= sp - 1;
  end

  cfe_checker u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] pc, input logic [31:0] ins, input logic [31:0] npc);
    @(negedge clk);
    ev_valid = 1; ev_pc = pc; ev_instr = ins; ev_npc = npc;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    ev_valid = 0; ev_instr = I_NOP;
    #1;
  endtask

  task automatic reboot(input bit chk);
    @(negedge clk);
    rst_n = 0; cfg_done = 0; ev_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    if (chk) begin
      check("R1 rst_req held", core_rst_req, 1);
      check("R1 no stall", stall_req, 0);
      check("R1 no push/pop", {ss_push, ss_pop}, 0);
    end
    @(negedge clk);
    if (chk) begin #1; check("R1 rst_req before cfg_done", core_rst_req, 1); end
    @(negedge clk);
    cfg_done = 1;
    #1;
    if (chk) begin
      check("R8 start fetch en", tt_en, 1);
      check("R1 start fetch addr", tt_addr, 0);
    end
    @(negedge clk);
    #1;
    if (chk) check("R1 released", core_rst_req, 0);
  endtask

  localparam int NV = 5;
  localparam logic [31:0] V_PC  [NV] = '{32'h110, 32'h204, 32'h214, 32'h114, 32'h11c};
  localparam logic [31:0] V_INS [NV] = '{I_CALL, I_BEQ, I_RET, I_NOP, I_RET};
  localparam logic [31:0] V_NPC [NV] = '{32'h200, 32'h210, 32'h114, 32'h118, 32'h0};
  localparam logic [5:0]  V_ADR [NV] = '{6'd16, 6'd17, 6'd3, 6'd0, 6'd0};
  localparam logic [3:0]  V_EXP [NV] = '{4'b1100, 4'b1000, 4'b1010, 4'b0000, 4'b0001}; // fire,push,pop,viol
  localparam string       V_REQ [NV] = '{"R5 R2 call", "R3 local branch", "R6 return",
                                         "R10 non-cf", "R6 R7 return empty stack"};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ev_instr = I_NOP;
    reboot(1);
    for (int i = 0; i < NV; i++) begin
      drive(V_PC[i], V_INS[i], V_NPC[i]);
      check({V_REQ[i], " fetch"}, tt_en, V_EXP[i][3]);
      if (V_EXP[i][3]) check({V_REQ[i], " R8 addr"}, tt_addr, V_ADR[i]);
      check({V_REQ[i], " push"}, ss_push, V_EXP[i][2]);
      check({V_REQ[i], " pop"}, ss_pop, V_EXP[i][1]);
      check({V_REQ[i], " reset"}, core_rst_req, V_EXP[i][0]);
      check({V_REQ[i], " stall"}, stall_req, 0);
      if (V_EXP[i][2]) check("R5 push record", {ss_push_mach, ss_push_state}, 6'h03);
      idle();
    end
    check("R7 sticky after fault", core_rst_req, 1);

    // R4 untaken branch, then R9 back-to-back stall
    reboot(0);
    drive(32'h104, I_BEQ, 32'h108);
    check("R4 fallthrough fetch", {tt_en, tt_addr}, {1'b1, 6'd1});
    drive(32'h10c, I_JMP, 32'h140);
    check("R9 stall", stall_req, 1);
    check("R9 no fetch while stalled", tt_en, 0);
    @(negedge clk);
    #1;
    check("R9 stall released", stall_req, 0);
    check("R3 R9 jump after stall", {tt_en, tt_addr}, {1'b1, 6'd3});
    idle();

    // R3 taken branch via local table
    reboot(0);
    drive(32'h104, I_BEQ, 32'h120);
    check("R3 taken branch", {tt_en, tt_addr, core_rst_req}, {1'b1, 6'd2, 1'b0});
    idle();

    // R7 illegal target
    reboot(0);
    drive(32'h104, I_BEQ, 32'h150);
    check("R7 immediate reset", core_rst_req, 1);
    check("R7 no fetch", tt_en, 0);
    idle();
    check("R7 reset persists", core_rst_req, 1);

    // R6 return from a non-accepting state
    reboot(0);
    drive(32'h110, I_CALL, 32'h200);
    check("R5 call fetch", {tt_en, tt_addr}, {1'b1, 6'd16});
    idle();
    drive(32'h208, I_RET, 32'h114);
    check("R6 non-accepting return", core_rst_req, 1);
    check("R6 no pop", ss_pop, 0);
    idle();

    // R2 indirect call form
    reboot(0);
    drive(32'h110, I_ICALL, 32'h200);
    check("R2 indirect call push", {ss_push, tt_addr}, {1'b1, 6'd16});
    idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule